// File: doc/BRIEF.md
# Sa6 Spare-Bit Code Detector

This block watches the Sa6 national spare bit recovered from received E1 frames and recognises five repeating 4-bit codes carried in it. A code counts as present only after the same nibble has been seen three times in a row. Each code has its own status bit, at most one of them is set at a time, and a one-cycle interrupt pulse marks the moment a status bit turns on.

Detection runs in one of two modes, selected by `sync_en`. In the free-running mode every received Sa6 bit enters a 12-bit sliding window, and the window is judged after each bit, so a code is found at whatever bit phase it arrives. This mode works while basic frame alignment is held. In the submultiframe-locked mode the window is judged only at submultiframe boundary strobes, so nibbles line up with the CRC-4 structure. This mode works only while CRC-4 multiframe alignment is held.

A small history controller has three states. IDLE: the required alignment is missing, or the mode has just changed, and the history is emptied. FILL: alignment is present and fewer than three nibbles' worth of events have arrived. WATCH: the history is full and every event is judged. Transitions: any state goes to IDLE when the alignment drops or the mode changes. IDLE goes to FILL when alignment is present, or straight to WATCH if the threshold is reached in that cycle. FILL goes to WATCH on the event that fills the history. WATCH stays in WATCH while alignment holds.

Top module: `sa6_code_detect`

## Requirements
- R1: After reset `code_status` is 0, `code_irq` is 0 and the history is empty.
- R2: Status bit index maps to code, with the first received bit as the nibble MSB: bit0 = 1000, bit1 = 1010, bit2 = 1100, bit3 = 1110, bit4 = 1111.
- R3: A code is declared only when the 12-bit window holds three identical nibbles of that code; fewer than 12 bits (free-running) or three boundaries (locked) since the history was emptied never declare a code.
- R4: With `sync_en` = 0 the window is judged on every `sa6_valid` bit, at any bit offset, and only while `basic_align` = 1; with `basic_align` = 0 no status bit changes.
- R5: With `sync_en` = 1 the window is judged only in cycles with `smf_strobe` = 1 and only while `mf_align` = 1; a bit with `sa6_valid` in the same cycle as the strobe enters the window before it is judged.
- R6: A judged window of three identical nibbles that is a bit rotation of the current code keeps the status; one that is another listed code switches to that code; any other repeated nibble clears all status bits. A window whose three nibbles differ changes nothing.
- R7: At most one status bit is set at any time; declaring a new code clears the old one in the same cycle.
- R8: `code_irq` is high for exactly one cycle, at the same clock edge a status bit goes from 0 to 1, and not on a clear or a re-confirmation.
- R9: Loss of the alignment the current mode needs, or any change of `sync_en`, empties the history and leaves `code_status` unchanged; after that three fresh nibbles are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa6_bit | input | 1 | Received Sa6 bit |
| sa6_valid | input | 1 | Qualifies `sa6_bit` for one cycle |
| smf_strobe | input | 1 | Submultiframe boundary marker |
| basic_align | input | 1 | Basic frame alignment held |
| mf_align | input | 1 | CRC-4 multiframe alignment held |
| sync_en | input | 1 | 1 selects submultiframe-locked detection |
| code_status | output | 5 | One status bit per code (see R2) |
| code_irq | output | 1 | One-cycle pulse when a status bit sets |

## Verification
In the locked mode the last bit of a third nibble and the submultiframe boundary strobe can land in the same cycle, so shifting the bit and judging the window must both happen at one edge. The bench provokes this by driving the fourth bit of the third 1111 nibble together with the strobe, then expects bit4 of `code_status` set and exactly one interrupt pulse; if the judgement used the window before the shift, the code would be missed until the next boundary. A sliding-window case where a rotation-based clear and a new declaration follow each other on neighbouring bits is also judged through the final status and the pulse count.

// File: rtl/sa6_pkg.sv
package sa6_pkg;

    localparam int NIB_W   = 4;
    localparam int N_CODES = 5;

    // Code values, index 0 in the low nibble.
    localparam logic [NIB_W*N_CODES-1:0] CODE_TABLE = {4'hF, 4'hE, 4'hC, 4'hA, 4'h8};

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_WATCH = 2'd2
    } hist_state_e;

    function automatic logic [NIB_W-1:0] code_val(input int idx);
        return CODE_TABLE[idx*NIB_W +: NIB_W];
    endfunction

    // True when a equals b rotated by any amount.
    function automatic logic rot_match(input logic [NIB_W-1:0] a,
                                       input logic [NIB_W-1:0] b);
        logic             found;
        logic [NIB_W-1:0] rot;
        found = 1'b0;
        for (int r = 0; r < NIB_W; r++) begin
            for (int j = 0; j < NIB_W; j++) begin
                rot[j] = b[(j + r) % NIB_W];
            end
            if (rot == a) found = 1'b1;
        end
        return found;
    endfunction

endpackage

// File: rtl/sa6_history.sv
module sa6_history
    import sa6_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   shift_en,
    input  logic                   bit_in,
    input  logic                   count_en,
    input  logic [CNT_W-1:0]       thr,
    output logic [NIB_W*DEPTH-1:0] win_nx,
    output logic                   reached
);
    localparam int WIN_W = NIB_W * DEPTH;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        win_nx  = shift_en ? {win_q[WIN_W-2:0], bit_in} : win_q;
        cnt_nx  = (count_en && (cnt_q < thr)) ? cnt_q + 1'b1 : cnt_q;
        reached = (cnt_nx >= thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_nx;
            cnt_q <= cnt_nx;
        end
    end

    // R3: the fill counter never passes the active threshold
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(WIN_W)));

endmodule

// File: rtl/sa6_ctrl.sv
module sa6_ctrl
    import sa6_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic event_i,
    input  logic reached,
    output logic hist_clr,
    output logic eval
);
    hist_state_e state_q;
    hist_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (run) state_d = reached ? S_WATCH : S_FILL;
            end
            S_FILL: begin
                if (!run)         state_d = S_IDLE;
                else if (reached) state_d = S_WATCH;
            end
            S_WATCH: begin
                if (!run) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hist_clr = !run;
        eval     = run && event_i && ((state_q == S_WATCH) || reached);
    end

    // R9: losing alignment or changing mode lands in IDLE
    a_r9_idle_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == S_IDLE));

    // R3: a judgement in FILL only happens on the filling event
    a_r3_fill_judge: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && state_q != S_WATCH) |=> (state_q == S_WATCH));

endmodule

// File: rtl/sa6_judge.sv
module sa6_judge
    import sa6_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eval,
    input  logic [NIB_W*DEPTH-1:0] win,
    output logic [N_CODES-1:0]     status,
    output logic                   irq
);
    logic [N_CODES-1:0] status_q;
    logic [N_CODES-1:0] status_d;
    logic [N_CODES-1:0] hit_vec;
    logic [NIB_W-1:0]   nib0;
    logic [NIB_W-1:0]   cur;
    logic               same;
    logic               irq_q;
    logic               irq_d;

    always_comb begin
        nib0 = win[NIB_W-1:0];
        same = 1'b1;
        for (int k = 1; k < DEPTH; k++) begin
            if (win[k*NIB_W +: NIB_W] != nib0) same = 1'b0;
        end
        cur = '0;
        for (int i = 0; i < N_CODES; i++) begin
            hit_vec[i] = (nib0 == code_val(i));
            if (status_q[i]) cur = code_val(i);
        end
        status_d = status_q;
        if (eval && same) begin
            if (!((|status_q) && rot_match(nib0, cur))) status_d = hit_vec;
        end
        irq_d = |(status_d & ~status_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= irq_d;
        end
    end

    assign status = status_q;
    assign irq    = irq_q;

    // R7: never more than one code flagged
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_q));

    // R8: a pulse only accompanies a rising status bit
    a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((status_q & ~$past(status_q)) != '0));

    // R8: the pulse lasts one cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R4: status moves only on a judged event
    a_r4_hold_without_eval: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(status_q));

endmodule

// File: rtl/sa6_code_detect.sv
module sa6_code_detect
    import sa6_pkg::*;
#(
    parameter int HIST_NIBBLES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sa6_bit,
    input  logic               sa6_valid,
    input  logic               smf_strobe,
    input  logic               basic_align,
    input  logic               mf_align,
    input  logic               sync_en,
    output logic [N_CODES-1:0] code_status,
    output logic               code_irq
);
    localparam int WIN_W = NIB_W * HIST_NIBBLES;
    localparam int CNT_W = $clog2(WIN_W + 1);

    logic             mode_q;
    logic             gate;
    logic             run;
    logic             event_sel;
    logic [CNT_W-1:0] thr;
    logic [WIN_W-1:0] win_nx;
    logic             reached;
    logic             hist_clr;
    logic             eval;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= sync_en;
    end

    always_comb begin
        gate      = sync_en ? mf_align : basic_align;
        run       = gate && (sync_en == mode_q);
        event_sel = sync_en ? smf_strobe : sa6_valid;
        thr       = sync_en ? CNT_W'(HIST_NIBBLES) : CNT_W'(WIN_W);
    end

    sa6_history #(.DEPTH(HIST_NIBBLES), .CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hist_clr),
        .shift_en (sa6_valid),
        .bit_in   (sa6_bit),
        .count_en (event_sel),
        .thr      (thr),
        .win_nx   (win_nx),
        .reached  (reached)
    );

    sa6_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .event_i  (event_sel),
        .reached  (reached),
        .hist_clr (hist_clr),
        .eval     (eval)
    );

    sa6_judge #(.DEPTH(HIST_NIBBLES)) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval   (eval),
        .win    (win_nx),
        .status (code_status),
        .irq    (code_irq)
    );

    // R9: dropping the needed alignment leaves status alone
    a_r9_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> $stable(code_status));

    // R5: in locked mode nothing is judged without a boundary strobe
    a_r5_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !smf_strobe) |=> $stable(code_status));

endmodule

// File: tb/sa6_code_detect_test.sv
module sa6_code_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    // {sync, nibble, reps, expected status, expected irq pulses}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 4'h8, 4'd2, 5'b00000, 2'd0},
        {1'b0, 4'h8, 4'd1, 5'b00001, 2'd1},
        {1'b0, 4'h8, 4'd3, 5'b00001, 2'd0},
        {1'b0, 4'hA, 4'd2, 5'b00001, 2'd0},
        {1'b0, 4'hA, 4'd1, 5'b00010, 2'd1},
        {1'b0, 4'hF, 4'd3, 5'b10000, 2'd1},
        {1'b0, 4'h0, 4'd3, 5'b00000, 2'd0},
        {1'b0, 4'hE, 4'd3, 5'b01000, 2'd1},
        {1'b1, 4'hC, 4'd2, 5'b01000, 2'd0},
        {1'b1, 4'hC, 4'd1, 5'b00100, 2'd1},
        {1'b1, 4'h8, 4'd2, 5'b00100, 2'd0},
        {1'b1, 4'h8, 4'd1, 5'b00001, 2'd1},
        {1'b1, 4'h3, 4'd3, 5'b00000, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sa6_bit = 1'b0;
    logic       sa6_valid = 1'b0;
    logic       smf_strobe = 1'b0;
    logic       basic_align = 1'b1;
    logic       mf_align = 1'b1;
    logic       sync_en = 1'b0;
    logic [4:0] code_status;
    logic       code_irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    int irq_run = 0;
    int irq_max = 0;
    bit done = 1'b0;

    sa6_code_detect uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sa6_bit     (sa6_bit),
        .sa6_valid   (sa6_valid),
        .smf_strobe  (smf_strobe),
        .basic_align (basic_align),
        .mf_align    (mf_align),
        .sync_en     (sync_en),
        .code_status (code_status),
        .code_irq    (code_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (code_irq) begin
            irq_cnt++;
            irq_run++;
            if (irq_run > irq_max) irq_max = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic strobe);
        @(negedge clk);
        sa6_bit = b; sa6_valid = 1'b1; smf_strobe = strobe;
        @(negedge clk);
        sa6_valid = 1'b0; smf_strobe = 1'b0;
    endtask

    task automatic send_nib(input logic [3:0] v, input logic locked);
        for (int j = 3; j >= 0; j--) send_bit(v[j], 1'b0);
        if (locked) begin
            @(negedge clk); smf_strobe = 1'b1;
            @(negedge clk); smf_strobe = 1'b0;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", int'(code_status), 0);
        check("R1 irq", int'(code_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            if (sync_en != VEC[i][15]) begin
                @(negedge clk);
                sync_en = VEC[i][15];
            end
            irq_cnt = 0;
            for (int r = 0; r < int'(VEC[i][10:7]); r++) send_nib(VEC[i][14:11], VEC[i][15]);
            settle();
            check($sformatf("R2/R3/R6 vec%0d status", i), int'(code_status), int'(VEC[i][6:2]));
            check($sformatf("R8 vec%0d irq count", i), irq_cnt, int'(VEC[i][1:0]));
        end

        // R5: last bit and boundary strobe in the same cycle
        irq_cnt = 0;
        send_nib(4'hF, 1'b1);
        send_nib(4'hF, 1'b1);
        check("R5 before third boundary", int'(code_status), 0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        settle();
        check("R5 joint bit+strobe status", int'(code_status), 5'b10000);
        check("R8 joint irq count", irq_cnt, 1);

        // R9 / R5: multiframe alignment loss in locked mode
        @(negedge clk); mf_align = 1'b0;
        settle();
        check("R9 status kept on loss", int'(code_status), 5'b10000);
        for (int r = 0; r < 3; r++) send_nib(4'hE, 1'b1);
        settle();
        check("R5 no detect without mf_align", int'(code_status), 5'b10000);
        @(negedge clk); mf_align = 1'b1;
        send_nib(4'hE, 1'b1);
        send_nib(4'hE, 1'b1);
        settle();
        check("R9 history emptied", int'(code_status), 5'b10000);
        send_nib(4'hE, 1'b1);
        settle();
        check("R9 fresh three nibbles", int'(code_status), 5'b01000);

        // R4: free-running mode needs basic alignment
        @(negedge clk); sync_en = 1'b0; basic_align = 1'b0;
        for (int r = 0; r < 3; r++) send_nib(4'hC, 1'b0);
        settle();
        check("R4 no detect without basic_align", int'(code_status), 5'b01000);
        @(negedge clk); basic_align = 1'b1;
        irq_cnt = 0;
        for (int r = 0; r < 3; r++) send_nib(4'hC, 1'b0);
        settle();
        check("R4 detect with basic_align", int'(code_status), 5'b00100);
        check("R8 R4 irq count", irq_cnt, 1);

        // R9: a mode change empties the history
        send_nib(4'hA, 1'b0);
        send_nib(4'hA, 1'b0);
        @(negedge clk); sync_en = 1'b1;
        @(negedge clk); sync_en = 1'b0;
        send_nib(4'hA, 1'b0);
        settle();
        check("R9 mode toggle clears history", int'(code_status), 5'b00100);
        send_nib(4'hA, 1'b0);
        send_nib(4'hA, 1'b0);
        settle();
        check("R2 R7 code 1010 replaces 1100", int'(code_status), 5'b00010);

        // R8: no pulse ever wider than one cycle
        check("R8 pulse width", irq_max, 1);

        // R1 / R3: reset mid-run, then two nibbles are not enough
        @(negedge clk); rst_n = 1'b0;
        settle();
        check("R1 status after reset", int'(code_status), 0);
        @(negedge clk); rst_n = 1'b1;
        send_nib(4'hC, 1'b0);
        send_nib(4'hC, 1'b0);
        settle();
        check("R3 two nibbles only", int'(code_status), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule